// File: doc/BRIEF.md
# Multi-Frame Stream Capture Packer

This block takes complex baseband samples from a receive chain and sends them out on a 128-bit AXI4-Stream master. The real and imaginary parts arrive as signed 25-bit values with 23 fractional bits. Each part is first reduced to signed 16-bit Q1.15, with rounding and saturation. The two results form one 32-bit word, and four such words make up one output beat.

A single-cycle trigger pulse starts a capture. The block then collects a programmed number of 512-sample frames, one directly after another, and returns to idle. TLAST marks the final beat of every frame, so a stream consumer can rebuild the frame boundaries without knowing the frame count.

While no capture is running, the output is quiet: TVALID is low and TDATA reads zero. When the consumer applies backpressure, the block holds the current beat and stalls its sample input, so no sample is lost.

Top module: `frame_capture_packer`

## Requirements
- R1: Each component is converted as out = floor((x + 128) / 256), where x is the signed 25-bit input with 23 fractional bits and out is signed Q1.15. This is rounding to nearest, with halves rounded toward positive infinity.
- R2: A converted value above 32767 becomes 0x7FFF. A converted value below -32768 becomes 0x8000.
- R3: Within each 32-bit word, the real part sits in bits [31:16] and the imaginary part in bits [15:0]. The k-th accepted sample of a group of four occupies TDATA bits [32k+31:32k], so sample 0 is in bits [31:0].
- R4: TLAST is high on the 128th beat of every frame and low on every other beat.
- R5: A trigger accepted while idle produces exactly n_frames × 128 beats, after which the block returns to idle. An n_frames value of 0 is treated as 1. The n_frames value is latched in the cycle the trigger is taken.
- R6: While no capture is running, TVALID is 0, TDATA is 0 and in_ready is 1. Samples offered in that time are discarded and produce no beat. This includes samples offered in the same cycle as the trigger.
- R7: While TVALID is high and TREADY is low, TDATA and TLAST stay stable. When a full group waits on a stalled output, in_ready goes low, and no accepted sample is ever lost.
- R8: A trigger that arrives while a capture is running, or while its final beat is still draining, has no effect on the number of beats produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on in_re / in_im |
| in_ready | output | 1 | Sample is taken when in_valid and in_ready are both high |
| in_re | input | 25 | Real part, signed, 23 fractional bits |
| in_im | input | 25 | Imaginary part, signed, 23 fractional bits |
| trigger | input | 1 | Starts a capture when the block is idle |
| n_frames | input | 8 | Number of frames to capture per trigger (0 is treated as 1) |
| m_tdata | output | 128 | Four packed complex samples |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Consumer ready |
| m_tlast | output | 1 | Last beat of a frame |

## Verification
A lane counter that slips shows up at once as rotated or mixed words in the very next beat. A frame or beat counter that is off shifts TLAST by at least one beat within 128 beats, or leaves the total beat count wrong by the time the capture ends. A state machine that fails to leave the capture state, or that re-arms on a trigger mid-capture, appears as surplus beats or as a non-zero TDATA once the expected stream has drained. Backpressure faults appear in the first stalled cycle as a changed beat, or later as a missing sample that shifts every following word.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/cap_requant.sv
// Signed fixed-point narrowing: round half up, then clamp to the output range.
module cap_requant #(
  parameter int IN_W     = 25,
  parameter int IN_FRAC  = 23,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 15
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int SHIFT = IN_FRAC - OUT_FRAC;
  localparam int SUM_W = IN_W + 1;
  localparam int Q_W   = SUM_W - SHIFT;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (SHIFT - 1);

  logic [SUM_W-1:0] sum;
  logic [Q_W-1:0]   q;
  logic             pos_ovf, neg_ovf;

  always_comb begin
    sum     = {din[IN_W-1], din} + HALF;
    q       = sum[SUM_W-1:SHIFT];
    pos_ovf = !q[Q_W-1] && (|q[Q_W-2:OUT_W-1]);
    neg_ovf = q[Q_W-1] && !(&q[Q_W-2:OUT_W-1]);
    if (pos_ovf)      dout = {1'b0, {(OUT_W-1){1'b1}}};
    else if (neg_ovf) dout = {1'b1, {(OUT_W-1){1'b0}}};
    else              dout = q[OUT_W-1:0];
  end

  // A clamped or rounded result never flips the sign of the input.
  always_comb begin
    if (!$isunknown(din))
      AST_SIGN_KEPT: assert (dout == '0 || dout[OUT_W-1] == din[IN_W-1]); // R2
  end
endmodule

// File: rtl/cap_lane_packer.sv
// Collects LANES words; the final lane is passed straight through into the beat.
module cap_lane_packer #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic [WORD_W-1:0]       word,
  output logic                    lane_last,
  output logic [LANES*WORD_W-1:0] beat
);
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane;

  always_ff @(posedge clk) begin
    if (rst)       lane <= '0;
    else if (take) lane <= lane_last ? '0 : lane + 1'b1;
  end

  assign lane_last = (lane == LANE_W'(LANES - 1));

  for (genvar k = 0; k < LANES - 1; k++) begin : g_slot
    logic [WORD_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (rst)                                slot <= '0;
      else if (take && lane == LANE_W'(k))    slot <= word;
    end
    assign beat[k*WORD_W +: WORD_W] = slot;
  end
  assign beat[(LANES-1)*WORD_W +: WORD_W] = word;
endmodule

// File: rtl/cap_out_reg.sv
// Registered stream output; data returns to zero once a beat leaves.
module cap_out_reg #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              last_in,
  input  logic              tready,
  output logic              tvalid,
  output logic [DATA_W-1:0] tdata,
  output logic              tlast
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tvalid <= 1'b0;
      tdata  <= '0;
      tlast  <= 1'b0;
    end else if (load) begin
      tvalid <= 1'b1;
      tdata  <= din;
      tlast  <= last_in;
    end else if (tready) begin
      tvalid <= 1'b0;
      tdata  <= '0;
      tlast  <= 1'b0;
    end
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    tvalid && !tready |=> tvalid && $stable(tdata) && $stable(tlast)); // R7
endmodule

// File: rtl/frame_capture_packer.sv
module frame_capture_packer
  import cap_pkg::*;
#(
  parameter int SAMPLE_W  = 25,
  parameter int IN_FRAC   = 23,
  parameter int COMP_W    = 16,
  parameter int COMP_FRAC = 15,
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 512,
  parameter int NF_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [SAMPLE_W-1:0]          in_re,
  input  logic [SAMPLE_W-1:0]          in_im,
  input  logic                         trigger,
  input  logic [NF_W-1:0]              n_frames,
  output logic [LANES*2*COMP_W-1:0]    m_tdata,
  output logic                         m_tvalid,
  input  logic                         m_tready,
  output logic                         m_tlast
);
  localparam int WORD_W = 2 * COMP_W;
  localparam int DATA_W = LANES * WORD_W;
  localparam int BEATS  = FRAME_LEN / LANES;
  localparam int BEAT_W = $clog2(BEATS);

  cap_state_e        state;
  logic [NF_W-1:0]   target, frame_cnt;
  logic [BEAT_W-1:0] beat_cnt;
  logic [COMP_W-1:0] re_q, im_q;
  logic [DATA_W-1:0] beat;
  logic              lane_last, out_free, accept, load, beat_end, frame_end;

  cap_requant #(.IN_W(SAMPLE_W), .IN_FRAC(IN_FRAC), .OUT_W(COMP_W), .OUT_FRAC(COMP_FRAC))
    u_rq_re (.din(in_re), .dout(re_q));
  cap_requant #(.IN_W(SAMPLE_W), .IN_FRAC(IN_FRAC), .OUT_W(COMP_W), .OUT_FRAC(COMP_FRAC))
    u_rq_im (.din(in_im), .dout(im_q));

  assign out_free  = !m_tvalid || m_tready;
  assign in_ready  = (state != ST_CAPTURE) || !lane_last || out_free;
  assign accept    = (state == ST_CAPTURE) && in_valid && in_ready;
  assign load      = accept && lane_last;
  assign beat_end  = (beat_cnt == BEAT_W'(BEATS - 1));
  assign frame_end = (frame_cnt == target - 1'b1);

  cap_lane_packer #(.LANES(LANES), .WORD_W(WORD_W)) u_packer (
    .clk(clk), .rst(rst), .take(accept), .word({re_q, im_q}),
    .lane_last(lane_last), .beat(beat)
  );

  cap_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(load), .din(beat), .last_in(beat_end),
    .tready(m_tready), .tvalid(m_tvalid), .tdata(m_tdata), .tlast(m_tlast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      target    <= NF_W'(1);
      frame_cnt <= '0;
      beat_cnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trigger) begin
          state     <= ST_CAPTURE;
          target    <= (n_frames == '0) ? NF_W'(1) : n_frames;
          frame_cnt <= '0;
          beat_cnt  <= '0;
        end
        ST_CAPTURE: if (load) begin
          if (beat_end) begin
            beat_cnt <= '0;
            if (frame_end) begin
              frame_cnt <= '0;
              state     <= ST_DONE;
            end else begin
              frame_cnt <= frame_cnt + 1'b1;
            end
          end else begin
            beat_cnt <= beat_cnt + 1'b1;
          end
        end
        ST_DONE: if (!m_tvalid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent beat counter on the output handshake, used only by checks.
  logic [BEAT_W-1:0] hs_cnt;
  always_ff @(posedge clk) begin
    if (rst) hs_cnt <= '0;
    else if (m_tvalid && m_tready)
      hs_cnt <= (hs_cnt == BEAT_W'(BEATS - 1)) ? '0 : hs_cnt + 1'b1;
  end

  AST_TLAST_PERIOD: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tready |-> m_tlast == (hs_cnt == BEAT_W'(BEATS - 1))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> !m_tvalid && m_tdata == '0 && in_ready); // R6

  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    state == ST_CAPTURE && trigger && !load |=> state == ST_CAPTURE && $stable(frame_cnt)); // R8

  AST_STALL_ONLY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_ready |-> state == ST_CAPTURE && m_tvalid && !m_tready); // R7
endmodule

// File: tb/frame_capture_packer_bench.sv
module frame_capture_packer_bench;
  localparam int LANES = 4;
  localparam int FRAME_LEN = 512;
  localparam int BEATS = FRAME_LEN / LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         in_valid = 1'b0, trigger = 1'b0, m_tready = 1'b1;
  logic [24:0]  in_re = '0, in_im = '0;
  logic [7:0]   n_frames = 8'd1;
  logic         in_ready, m_tvalid, m_tlast;
  logic [127:0] m_tdata;

  frame_capture_packer u_frame_capture_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .trigger(trigger), .n_frames(n_frames),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  logic [127:0] exp_q[$];
  bit           last_q[$];
  int errors = 0, checks = 0, seen = 0, sidx = 0, lane = 0, beat_no = 0;
  bit bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [127:0] grp = '0;

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [24:0] gen(int i, bit im);
    int k, v;
    k = im ? (i + 3) % 16 : i % 16;
    case (k)
      0: v = 16777215;
      1: v = -16777216;
      2: v = 127;
      3: v = 128;
      4: v = -128;
      5: v = -129;
      6: v = 8388607;
      7: v = -8388608;
      default: v = ((i * 40503 + (im ? 12345 : 0)) % 33554432) - 16777216;
    endcase
    return v[24:0];
  endfunction

  // R1 R2: round half up by 256, then clamp to the Q1.15 range
  function automatic logic [15:0] rq(logic [24:0] x);
    int v;
    v = int'($signed(x));
    v = (v + 128) >>> 8;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v[15:0];
  endfunction

  // Backpressure source
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // Monitor / scoreboard
  bit stall_prev = 1'b0;
  logic [127:0] held = '0;
  logic held_last = 1'b0;
  always @(negedge clk) begin
    #3;
    if (!rst) begin
      if (stall_prev)
        check(m_tvalid && m_tdata == held && m_tlast == held_last, "R7", "beat changed under stall", m_tdata, held);
      stall_prev = m_tvalid && !m_tready;
      held = m_tdata;
      held_last = m_tlast;
      if (m_tvalid && m_tready) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected beat", m_tdata, '0);
        end else begin
          logic [127:0] e;
          bit l;
          e = exp_q.pop_front();
          l = last_q.pop_front();
          check(m_tdata == e, "R1 R2 R3", "beat data", m_tdata, e);
          check(m_tlast == l, "R4", "tlast", {127'd0, m_tlast}, {127'd0, l});
        end
      end
    end
  end

  task automatic run_capture(int nf_cfg, int nf_exp, bit poke, bit gaps);
    int total, got, cyc, seen0, wait_cyc;
    seen0 = seen;
    @(negedge clk);
    n_frames = 8'(nf_cfg);
    trigger = 1'b1;
    in_valid = 1'b1;              // offered with the trigger: must be dropped (R6)
    in_re = 25'h0ABCDE;
    in_im = 25'h1234;
    @(negedge clk);
    trigger = 1'b0;
    total = nf_exp * FRAME_LEN;
    got = 0;
    cyc = 0;
    while (got < total) begin
      in_valid = gaps ? (cyc % 5 != 2) : 1'b1;
      in_re = gen(sidx, 1'b0);
      in_im = gen(sidx, 1'b1);
      trigger = poke && (cyc == 300 || cyc == 301); // R8: mid-capture trigger
      #3;
      if (in_valid && in_ready) begin
        grp[lane*32 +: 32] = {rq(in_re), rq(in_im)};
        lane++;
        got++;
        sidx++;
        if (lane == LANES) begin
          lane = 0;
          exp_q.push_back(grp);
          last_q.push_back(beat_no == BEATS - 1);
          beat_no = (beat_no + 1) % BEATS;
        end
      end
      cyc++;
      @(negedge clk);
    end
    trigger = poke;               // R8: trigger while the last beat drains
    in_valid = 1'b1;
    for (int j = 0; j < 6; j++) begin
      in_re = gen(j + 7, 1'b0);
      in_im = gen(j + 9, 1'b1);
      @(negedge clk);
      trigger = 1'b0;
    end
    in_valid = 1'b0;
    wait_cyc = 0;
    while (exp_q.size() > 0 && wait_cyc < 4000) begin
      @(negedge clk);
      wait_cyc++;
    end
    repeat (6) @(negedge clk);
    #3;
    check(!m_tvalid && m_tdata == '0, "R6", "output not quiet after capture", {m_tvalid, m_tdata[126:0]}, '0);
    check(seen - seen0 == nf_exp * BEATS, "R5", "beat count per trigger", 128'(seen - seen0), 128'(nf_exp * BEATS));
    if (poke)
      check(seen - seen0 == nf_exp * BEATS, "R8", "extra trigger changed beat count", 128'(seen - seen0), 128'(nf_exp * BEATS));
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R5", "watchdog expired", '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #3;
    check(!m_tvalid && m_tdata == '0 && !m_tlast, "R6", "reset state", {m_tvalid, m_tlast, m_tdata[125:0]}, '0);
    @(negedge clk);
    rst = 1'b0;
    // R6: samples while idle are taken and discarded
    in_valid = 1'b1;
    for (int j = 0; j < 20; j++) begin
      in_re = gen(j, 1'b0);
      in_im = gen(j, 1'b1);
      @(negedge clk);
    end
    #3;
    check(in_ready && !m_tvalid && m_tdata == '0, "R6", "idle with samples offered", {in_ready, m_tvalid, m_tdata[125:0]}, {1'b1, 127'd0});
    in_valid = 1'b0;
    run_capture(1, 1, 1'b0, 1'b0);   // R1 R2 R3 R4 R5
    run_capture(0, 1, 1'b0, 1'b0);   // R5: zero means one frame
    bp_mode = 1'b1;
    run_capture(3, 3, 1'b1, 1'b1);   // R7 R8 with gaps and backpressure
    bp_mode = 1'b0;
    run_capture(2, 2, 1'b0, 1'b1);   // R5 two frames
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule